// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the command front end of a byte-wide parallel NOR-style flash. It samples the active-low chip select, write strobe and read strobe into the system clock domain and qualifies write cycles from them. For each accepted cycle it captures an address and a data byte. It decodes one- and two-write command sequences into single-cycle requests to a separate program/erase sequencer: start a byte program, start a chip erase, or abort. The memory array, the program and erase timing, and the voltage detectors lie outside the block. The high-voltage-present and supply-good conditions reach it as synchronous flags, and the sequencer reports the end of an operation through `op_done`.

The decoder also chooses what a read returns. In normal mode the read port carries the array byte presented on `array_data`. In identifier mode it carries a manufacturer or device code, selected by address bit 0. A registered drive flag stands in for the tri-state control of the data bus.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write is accepted only when chip select and write strobe are both low and the read strobe is high. A cycle ends, and is committed, when chip select or write strobe rises while the read strobe is still high. A cycle during which the read strobe is low, or one in which chip select never falls, has no effect.
- R2: The address is captured at the later of the two falling edges of chip select and write strobe. The data byte is captured at the earlier of their two rising edges.
- R3: While `hv_ok` is low the mode is forced to normal read one cycle later, no start request is issued, and all writes are ignored. Writing 80h during that time does not select identifier mode.
- R4: Writing 00h or FFh selects normal read mode, and reads then return `array_data`. Writing 80h or 90h selects identifier mode: with address bit 0 = 0 a read returns 01h, and with bit 0 = 1 it returns 2Fh. Any code not listed in R4 to R6 selects normal read mode.
- R5: Writing 30h on two consecutive accepted writes raises `start_erase` for one cycle after the second write. One 30h followed by another code never starts an erase.
- R6: After 10h or 50h the next accepted write of any value raises `start_prog` for one cycle, with `prog_addr` and `prog_data` holding that write's address and data.
- R7: After 10h or 50h a first reset code (00h or FFh) is taken as program data and does not raise `abort_req`. A second reset code raises `abort_req` and returns to normal read mode.
- R8: In every mode other than program setup, a reset-code write raises `abort_req` for one cycle and selects normal read mode. While an erase or program is running, writes other than reset codes are ignored.
- R9: While `vcc_ok` is low, `abort_req` is high one cycle later, the mode returns to normal read, and writes are ignored.
- R10: Every identifier byte on `rd_data` has an odd number of ones, with bit 7 acting as the parity bit.
- R11: `rd_drive` is high only when chip select and read strobe are both low, after the synchronizer and one register.
- R12: While a program or erase is running, a pulse on `op_done` returns the decoder to normal read mode, so that a new command sequence can start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Read strobe, active low, asynchronous |
| hv_ok | input | 1 | High programming voltage present |
| vcc_ok | input | 1 | Supply above lockout threshold |
| op_done | input | 1 | Sequencer finished the running operation |
| addr_in | input | AW | Byte address from the bus |
| data_in | input | 8 | Write data from the bus |
| array_data | input | 8 | Array byte for the current address |
| start_prog | output | 1 | One-cycle request to program a byte |
| start_erase | output | 1 | One-cycle request to erase the chip |
| abort_req | output | 1 | Abort request to the sequencer |
| prog_addr | output | AW | Target address of the program request |
| prog_data | output | 8 | Byte to program |
| rd_data | output | 8 | Read data: array byte or identifier code |
| rd_drive | output | 1 | Data bus drive enable |

## Verification
The checker watches every cycle. It confirms that the two start requests never coincide and that each request follows the matching setup mode. It confirms that a low `hv_ok` or `vcc_ok` forces normal read mode and blocks start requests or raises an abort. It also confirms that identifier bytes leave with odd parity. Only the bench scenarios show the rest: which strobe edges capture address and data, that both strobe orders work, the doubled reset after program setup, and the sweep over all 256 command codes. These depend on sequences of bus cycles, not on a relation between neighbouring cycles.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    M_READ      = 3'd0,
    M_ID        = 3'd1,
    M_ERASE_SET = 3'd2,
    M_PROG_SET  = 3'd3,
    M_PROG_RUN  = 3'd4,
    M_ERASE_RUN = 3'd5
  } mode_e;

  localparam logic [7:0] ID_MFR_CODE = 8'h01;
  localparam logic [7:0] ID_DEV_CODE = 8'h2F;
  localparam logic [7:0] CMD_ERASE   = 8'h30;

  function automatic logic is_reset_code(input logic [7:0] b);
    return (b == 8'h00) || (b == 8'hFF);
  endfunction

  function automatic logic is_id_code(input logic [7:0] b);
    return (b == 8'h80) || (b == 8'h90);
  endfunction

  function automatic logic is_prog_code(input logic [7:0] b);
    return (b == 8'h10) || (b == 8'h50);
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int              WIDTH  = 3,
  parameter int              STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] shreg;
      always_ff @(posedge clk) begin
        if (rst) shreg <= {STAGES{IDLE[i]}};
        else     shreg <= {shreg[STAGES-2:0], d[i]};
      end
      assign q[i] = shreg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/write_qualifier.sv
module write_qualifier #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_s,
  input  logic          we_s,
  input  logic          oe_s,
  input  logic          enable,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_commit,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  logic active, active_q, begin_w, end_w;

  // both selects low with the read strobe high: cycle open
  assign active  = ~ce_s & ~we_s & oe_s;
  // opening happens at whichever select fell last
  assign begin_w = active & ~active_q;
  // closing at the first select to rise; a read strobe drop spoils it
  assign end_w   = active_q & ~active & oe_s & (ce_s | we_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      wr_commit <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      active_q  <= active;
      wr_commit <= end_w & enable;
      if (begin_w) wr_addr <= addr_in;
      if (end_w)   wr_data <= data_in;
    end
  end

endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hv_ok,
  input  logic          vcc_ok,
  input  logic          op_done,
  input  logic          wr_commit,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output mode_e         mode,
  output logic          start_prog,
  output logic          start_erase,
  output logic          abort_req,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data
);

  mode_e mode_n;
  logic  sp_n, se_n, ab_n, load_n;

  always_comb begin
    mode_n = mode;
    sp_n   = 1'b0;
    se_n   = 1'b0;
    ab_n   = 1'b0;
    load_n = 1'b0;
    if (!vcc_ok) begin
      mode_n = M_READ;
      ab_n   = 1'b1;
    end else if (!hv_ok) begin
      mode_n = M_READ;
    end else begin
      unique case (mode)
        M_PROG_SET: begin
          if (wr_commit) begin
            sp_n   = 1'b1;
            load_n = 1'b1;
            mode_n = M_PROG_RUN;
          end
        end
        M_PROG_RUN, M_ERASE_RUN: begin
          if (wr_commit && is_reset_code(wr_data)) begin
            ab_n   = 1'b1;
            mode_n = M_READ;
          end else if (op_done) begin
            mode_n = M_READ;
          end
        end
        default: begin
          if (wr_commit) begin
            if (is_reset_code(wr_data)) begin
              ab_n   = 1'b1;
              mode_n = M_READ;
            end else if (is_id_code(wr_data)) begin
              mode_n = M_ID;
            end else if (is_prog_code(wr_data)) begin
              mode_n = M_PROG_SET;
            end else if (wr_data == CMD_ERASE) begin
              if (mode == M_ERASE_SET) begin
                se_n   = 1'b1;
                mode_n = M_ERASE_RUN;
              end else begin
                mode_n = M_ERASE_SET;
              end
            end else begin
              mode_n = M_READ;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= M_READ;
      start_prog  <= 1'b0;
      start_erase <= 1'b0;
      abort_req   <= 1'b0;
      prog_addr   <= '0;
      prog_data   <= '0;
    end else begin
      mode        <= mode_n;
      start_prog  <= sp_n;
      start_erase <= se_n;
      abort_req   <= ab_n;
      if (load_n) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end

endmodule

// File: rtl/read_mux.sv
module read_mux
  import flash_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic          id_sel,
  input  logic          addr_lsb,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_drive
);

  logic [DW-1:0] id_byte;
  assign id_byte = addr_lsb ? DW'(ID_DEV_CODE) : DW'(ID_MFR_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_drive <= 1'b0;
    end else begin
      rd_data  <= id_sel ? id_byte : array_data;
      rd_drive <= ~ce_s & ~oe_s;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW          = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          hv_ok,
  input  logic          vcc_ok,
  input  logic          op_done,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    data_in,
  input  logic [7:0]    array_data,
  output logic          start_prog,
  output logic          start_erase,
  output logic          abort_req,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  output logic [7:0]    rd_data,
  output logic          rd_drive
);

  localparam int DW = 8;
  localparam int NSTROBE = 3;

  logic [NSTROBE-1:0] strobe_s;
  logic               ce_s, we_s, oe_s;
  logic               wr_commit;
  logic [AW-1:0]      wr_addr;
  logic [DW-1:0]      wr_data;
  mode_e              mode_w;

  strobe_sync #(.WIDTH(NSTROBE), .STAGES(SYNC_STAGES), .IDLE('1)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({oe_n, we_n, ce_n}),
    .q   (strobe_s)
  );

  assign ce_s = strobe_s[0];
  assign we_s = strobe_s[1];
  assign oe_s = strobe_s[2];

  write_qualifier #(.AW(AW), .DW(DW)) i_wq (
    .clk       (clk),
    .rst       (rst),
    .ce_s      (ce_s),
    .we_s      (we_s),
    .oe_s      (oe_s),
    .enable    (hv_ok & vcc_ok),
    .addr_in   (addr_in),
    .data_in   (data_in),
    .wr_commit (wr_commit),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  cmd_fsm #(.AW(AW), .DW(DW)) i_fsm (
    .clk         (clk),
    .rst         (rst),
    .hv_ok       (hv_ok),
    .vcc_ok      (vcc_ok),
    .op_done     (op_done),
    .wr_commit   (wr_commit),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .mode        (mode_w),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .abort_req   (abort_req),
    .prog_addr   (prog_addr),
    .prog_data   (prog_data)
  );

  read_mux #(.DW(DW)) i_rd (
    .clk        (clk),
    .rst        (rst),
    .ce_s       (ce_s),
    .oe_s       (oe_s),
    .id_sel     (mode_w == M_ID),
    .addr_lsb   (addr_in[0]),
    .array_data (array_data),
    .rd_data    (rd_data),
    .rd_drive   (rd_drive)
  );

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       hv_ok,
  input logic       vcc_ok,
  input logic       start_prog,
  input logic       start_erase,
  input logic       abort_req,
  input logic [7:0] rd_data,
  input mode_e      mode_w
);

  a_r5_single_start: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_prog, start_erase}));

  a_r5_erase_after_setup: assert property (@(posedge clk) disable iff (rst)
    start_erase |-> $past(mode_w) == M_ERASE_SET);

  a_r6_prog_after_setup: assert property (@(posedge clk) disable iff (rst)
    start_prog |-> $past(mode_w) == M_PROG_SET);

  a_r3_hv_blocks_start: assert property (@(posedge clk) disable iff (rst)
    !hv_ok |=> !(start_prog || start_erase));

  a_r3_hv_forces_read: assert property (@(posedge clk) disable iff (rst)
    !hv_ok |=> mode_w == M_READ);

  a_r9_vcc_abort: assert property (@(posedge clk) disable iff (rst)
    !vcc_ok |=> (abort_req && mode_w == M_READ));

  a_r10_odd_parity: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_w) == M_ID) |-> (($countones(rd_data) % 2) == 1));

endmodule

bind flash_cmd_decoder flash_cmd_checker i_chk (
  .clk         (clk),
  .rst         (rst),
  .hv_ok       (hv_ok),
  .vcc_ok      (vcc_ok),
  .start_prog  (start_prog),
  .start_erase (start_erase),
  .abort_req   (abort_req),
  .rd_data     (rd_data),
  .mode_w      (mode_w)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

  localparam int AW = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic hv_ok = 1'b1, vcc_ok = 1'b1, op_done = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0] data_in = '0;
  logic [7:0] array_data;
  logic start_prog, start_erase, abort_req, rd_drive;
  logic [AW-1:0] prog_addr;
  logic [7:0] prog_data, rd_data;

  int checks = 0, errors = 0;
  int n_prog = 0, n_erase = 0, n_abort = 0;
  logic [AW-1:0] cap_addr = '0;
  logic [7:0] cap_data = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] arr(input logic [AW-1:0] a);
    return a[7:0] ^ 8'hA5 ^ {1'b0, a[14:8]};
  endfunction

  assign array_data = arr(addr_in);

  flash_cmd_decoder #(.AW(AW)) i_flash_cmd_decoder (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .hv_ok(hv_ok), .vcc_ok(vcc_ok), .op_done(op_done),
    .addr_in(addr_in), .data_in(data_in), .array_data(array_data),
    .start_prog(start_prog), .start_erase(start_erase), .abort_req(abort_req),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (start_prog) begin
        n_prog++;
        cap_addr = prog_addr;
        cap_data = prog_data;
      end
      if (start_erase) n_erase++;
      if (abort_req) n_abort++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // generic write: first_ce selects which strobe falls first (and rises first)
  task automatic wr_full(input logic [AW-1:0] a_pre, input logic [AW-1:0] a_mid,
                         input logic [AW-1:0] a_post, input logic [7:0] d_pre,
                         input logic [7:0] d_post, input bit first_ce);
    addr_in = a_pre; data_in = d_pre;
    if (first_ce) ce_n = 1'b0; else we_n = 1'b0;
    waitn(5);
    addr_in = a_mid;
    if (first_ce) we_n = 1'b0; else ce_n = 1'b0;
    waitn(5);
    addr_in = a_post;
    if (first_ce) ce_n = 1'b1; else we_n = 1'b1;
    waitn(5);
    data_in = d_post;
    if (first_ce) we_n = 1'b1; else ce_n = 1'b1;
    waitn(5);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_full(a, a, a, d, d, 1'b0);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v, output logic drv);
    addr_in = a; ce_n = 1'b0; oe_n = 1'b0;
    waitn(6);
    v = rd_data; drv = rd_drive;
    ce_n = 1'b1; oe_n = 1'b1;
    waitn(4);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin : main
    logic [7:0] v;
    logic drv;
    int p0, e0, b0;
    waitn(4);
    rst = 1'b0;
    waitn(2);
    // reset state
    chk("reset start_prog", start_prog, 0);
    chk("reset start_erase", start_erase, 0);
    chk("reset abort_req", abort_req, 0);
    chk("R11 reset rd_drive", rd_drive, 0);
    rd(15'h0001, v, drv);
    chk("R4 reset mode reads array", v, arr(15'h0001));
    chk("R11 drive when ce,oe low", drv, 1);

    // R11 drive needs both low
    addr_in = 0; ce_n = 1'b0; waitn(6);
    chk("R11 ce low only", rd_drive, 0);
    ce_n = 1'b1; oe_n = 1'b0; waitn(6);
    chk("R11 oe low only", rd_drive, 0);
    oe_n = 1'b1; waitn(4);

    // R4 identifier mode
    wr(0, 8'h90);
    rd(15'h0000, v, drv); chk("R4 id addr0", v, 8'h01);
    rd(15'h0001, v, drv); chk("R4 id addr1", v, 8'h2F);
    chk("R10 parity dev", ($countones(v) % 2), 1);
    b0 = n_abort;
    wr(0, 8'h00);
    chk("R8 reset from id aborts", n_abort - b0, 1);
    rd(15'h0001, v, drv); chk("R4 00h back to array", v, arr(15'h0001));

    // R6 / R2 program with WE-first strobes
    p0 = n_prog;
    wr(0, 8'h10);
    wr_full(15'h1111, 15'h2222, 15'h3333, 8'h3C, 8'hC3, 1'b0);
    chk("R6 start_prog pulse", n_prog - p0, 1);
    chk("R2 addr at later fall (we first)", cap_addr, 15'h2222);
    chk("R2 data at first rise (we first)", cap_data, 8'h3C);
    op_done = 1'b1; waitn(1); op_done = 1'b0; waitn(2);
    // R2 with CE-first strobes
    wr(0, 8'h50);
    wr_full(15'h0ABC, 15'h4321, 15'h7000, 8'h5A, 8'hA5, 1'b1);
    chk("R6 start_prog via 50h", n_prog - p0, 2);
    chk("R2 addr at later fall (ce first)", cap_addr, 15'h4321);
    chk("R2 data at first rise (ce first)", cap_data, 8'h5A);
    op_done = 1'b1; waitn(1); op_done = 1'b0; waitn(2);

    // R12: returned to read, so 80h works
    wr(0, 8'h80);
    rd(15'h0001, v, drv); chk("R12 op_done returns to read", v, 8'h2F);
    wr(0, 8'hFF);

    // R1 write with oe low is ignored, ce high is ignored
    p0 = n_prog;
    wr(0, 8'h10);
    addr_in = 15'h0055; data_in = 8'h77;
    oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; waitn(6);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; waitn(6);
    chk("R1 oe-low cycle ignored", n_prog - p0, 0);
    we_n = 1'b0; waitn(6); we_n = 1'b1; waitn(6);
    chk("R1 ce-high cycle ignored", n_prog - p0, 0);
    wr(15'h0066, 8'h99);
    chk("R1 valid write accepted", n_prog - p0, 1);
    chk("R1 data of valid write", cap_data, 8'h99);
    wr(0, 8'hFF);

    // R7 doubled reset after program setup
    p0 = n_prog; b0 = n_abort;
    wr(0, 8'h10);
    wr(15'h0042, 8'hFF);
    chk("R7 first reset is program data", n_prog - p0, 1);
    chk("R7 first reset data FF", cap_data, 8'hFF);
    chk("R7 first reset no abort", n_abort - b0, 0);
    wr(0, 8'hFF);
    chk("R7 second reset aborts", n_abort - b0, 1);
    wr(0, 8'h80);
    rd(15'h0001, v, drv); chk("R7 back in read mode", v, 8'h2F);
    wr(0, 8'hFF);

    // R5 erase sequences
    e0 = n_erase;
    wr(0, 8'h30); wr(0, 8'h00);
    chk("R5 30h then reset no erase", n_erase - e0, 0);
    wr(0, 8'h30); wr(0, 8'h90); wr(0, 8'h30);
    chk("R5 interrupted 30h no erase", n_erase - e0, 0);
    wr(0, 8'h30);
    chk("R5 30h,30h starts erase", n_erase - e0, 1);
    // R8: non-reset write ignored while erasing
    wr(0, 8'h80);
    rd(15'h0001, v, drv); chk("R8 write ignored while erasing", v, arr(15'h0001));
    b0 = n_abort;
    wr(0, 8'hFF);
    chk("R8 reset aborts erase", n_abort - b0, 1);

    // R3 high voltage lockout
    p0 = n_prog;
    wr(0, 8'h90);
    hv_ok = 1'b0; waitn(3);
    rd(15'h0001, v, drv); chk("R3 hv low forces read", v, arr(15'h0001));
    wr(0, 8'h10); wr(15'h0011, 8'h22); wr(0, 8'h80);
    hv_ok = 1'b1; waitn(3);
    chk("R3 no program under hv low", n_prog - p0, 0);
    rd(15'h0001, v, drv); chk("R3 80h ignored under hv low", v, arr(15'h0001));

    // R9 supply lockout
    wr(0, 8'h90);
    vcc_ok = 1'b0; waitn(3);
    chk("R9 abort high while vcc low", abort_req, 1);
    wr(0, 8'h10); wr(15'h0011, 8'h22);
    vcc_ok = 1'b1; waitn(3);
    chk("R9 writes ignored under vcc low", n_prog - p0, 0);
    rd(15'h0001, v, drv); chk("R9 returned to read", v, arr(15'h0001));

    // R4/R6 sweep over every command code
    p0 = n_prog; e0 = n_erase;
    for (int c = 0; c < 256; c++) begin
      logic [7:0] code;
      logic [7:0] exp;
      code = 8'(c);
      wr(0, 8'hFF);
      wr(0, code);
      rd(15'h0001, v, drv);
      exp = (code == 8'h80 || code == 8'h90) ? 8'h2F : arr(15'h0001);
      chk($sformatf("R4 sweep code %02h", code), v, exp);
      if (code == 8'h10 || code == 8'h50) begin
        wr(0, 8'hFF); wr(0, 8'hFF);
      end else begin
        wr(0, 8'hFF);
      end
    end
    chk("R6 sweep program count", n_prog - p0, 2);
    chk("R5 sweep no erase", n_erase - e0, 0);

    finish_run();
  end

endmodule